// File: doc/BRIEF.md
# Interrupt Vector Fetch Inserter

This block sits beside the program counter of a three-stage fetch/decode/execute sequencer. It splices hardware interrupts into the instruction stream. Each interrupt line has its own start address. A request is caught in a pending latch. It is taken only when the sequencer reports an instruction boundary.

Once a request is taken, the block lets the program counter drive one more fetch, which is the decode cycle of the current instruction. It then steers the program address bus to the start address for one cycle, and to the start address plus one for the next cycle. From the first of these two vector fetches, it holds the program counter frozen. The freeze lasts until the sequencer signals that exception processing has finished.

When several lines are pending, the lowest-numbered one wins. Requests that arrive while an insertion is under way wait in the latch until the freeze ends.

Top module: `irq_fetch_inserter`

## Requirements
- R1: After reset, `irqAck` is 0, `pcHold` is 0 and `progAddr` equals `pcAddr`.
- R2: A pending request is taken only in a cycle where `instrBoundary` is 1. While `instrBoundary` stays 0, no acknowledge is given and `progAddr` follows `pcAddr`.
- R3: A request taken at a clock edge gives a one-cycle, one-hot `irqAck` in the next cycle. That cycle is the decode cycle: `progAddr` equals `pcAddr` and `pcHold` is 0.
- R4: In the cycle after the acknowledge, `progAddr` equals the winning line's start address and `pcHold` is 1.
- R5: In the cycle after that, `progAddr` equals the start address plus one, modulo 2^ADDR_W, and `pcHold` is still 1.
- R6: After the second vector fetch, `progAddr` follows `pcAddr` and `pcHold` stays 1 until `excDone` is 1. In the cycle after `excDone` is seen, `pcHold` is 0.
- R7: When several bits of the pending latch are set, the lowest index is acknowledged. `irqAck` bit i corresponds to `irqReq` bit i.
- R8: Acknowledging a line clears only that line's pending bit. Other pending lines are served in later insertions.
- R9: A request raised while `pcHold` is 1 gets no acknowledge during the freeze. It stays pending and is taken after the freeze ends.
- R10: The start address is captured when the request is taken. Changes on `vecAddr` after that point do not alter the two vector fetches.
- R11: `excDone` during either vector fetch cycle has no effect. The freeze still lasts until `excDone` is seen after the second vector fetch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| irqReq | input | NUM_REQ | Interrupt request lines; each 1 sets its pending bit |
| vecAddr | input | NUM_REQ*ADDR_W | Start addresses; line i occupies bits [i*ADDR_W +: ADDR_W] |
| pcAddr | input | ADDR_W | Program counter value from the sequencer |
| instrBoundary | input | 1 | 1 when the current cycle is an instruction boundary |
| excDone | input | 1 | 1 when exception processing has finished |
| progAddr | output | ADDR_W | Program address bus |
| pcHold | output | 1 | 1 while the program counter must stay frozen |
| irqAck | output | NUM_REQ | One-hot acknowledge of the request taken |

## Verification
A wrong sequencer state shows at the ports within one cycle. It appears as a vector fetch shifted by a cycle, a missing `+1` on the second word, a `pcHold` that rises early or drops before `excDone`, or an acknowledge during a freeze.

A wrong pending latch shows at the next boundary. A lost bit means a line is never acknowledged. A bit that is not cleared means the same line is acknowledged twice. A faulty priority encoder acknowledges the wrong line and sends the wrong start address on the bus two cycles later.

// File: rtl/irq_fetch_pkg.sv
package irq_fetch_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ARMED,
    ST_VEC0,
    ST_VEC1,
    ST_HOLD
  } seqState_t;

  typedef struct packed {
    logic accept;
    logic useVec0;
    logic useVec1;
    logic holdPc;
  } ctrlStrobe_t;

endpackage

// File: rtl/irq_fetch_ctrl.sv
module irq_fetch_ctrl
  import irq_fetch_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        anyPending,
  input  logic        instrBoundary,
  input  logic        excDone,
  output ctrlStrobe_t strobe
);

  seqState_t stateReg, stateNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stateReg <= ST_IDLE;
    else       stateReg <= stateNext;
  end

  always_comb begin
    stateNext = stateReg;
    unique case (stateReg)
      ST_IDLE:  if (anyPending && instrBoundary) stateNext = ST_ARMED;
      ST_ARMED: stateNext = ST_VEC0;
      ST_VEC0:  stateNext = ST_VEC1;
      ST_VEC1:  stateNext = ST_HOLD;
      ST_HOLD:  if (excDone) stateNext = ST_IDLE;
      default:  stateNext = ST_IDLE;
    endcase
  end

  always_comb begin
    strobe.accept  = (stateReg == ST_IDLE) && anyPending && instrBoundary;
    strobe.useVec0 = (stateReg == ST_VEC0);
    strobe.useVec1 = (stateReg == ST_VEC1);
    strobe.holdPc  = (stateReg == ST_VEC0) || (stateReg == ST_VEC1) ||
                     (stateReg == ST_HOLD);
  end

endmodule

// File: rtl/irq_fetch_dpath.sv
module irq_fetch_dpath
  import irq_fetch_pkg::*;
#(
  parameter int NUM_REQ = 4,
  parameter int ADDR_W  = 16
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic [NUM_REQ-1:0]        irqReq,
  input  logic [NUM_REQ*ADDR_W-1:0] vecAddr,
  input  logic [ADDR_W-1:0]         pcAddr,
  input  ctrlStrobe_t               strobe,
  output logic                      anyPending,
  output logic [ADDR_W-1:0]         progAddr,
  output logic                      pcHold,
  output logic [NUM_REQ-1:0]        irqAck
);

  localparam int IDX_W = (NUM_REQ > 1) ? $clog2(NUM_REQ) : 1;

  logic [NUM_REQ-1:0] pendReg;
  logic [NUM_REQ-1:0] winMask;
  logic [NUM_REQ-1:0] ackReg;
  logic [IDX_W-1:0]   winIdx;
  logic [ADDR_W-1:0]  vecReg;
  logic [ADDR_W-1:0]  vecArr [NUM_REQ];

  for (genvar g = 0; g < NUM_REQ; g++) begin : g_slice
    assign vecArr[g] = vecAddr[g*ADDR_W +: ADDR_W];
  end

  // lowest index wins: scan from the top so the last hit is the lowest
  always_comb begin
    winIdx = '0;
    for (int i = NUM_REQ - 1; i >= 0; i--) begin
      if (pendReg[i]) winIdx = IDX_W'(i);
    end
  end

  assign winMask    = NUM_REQ'(1) << winIdx;
  assign anyPending = |pendReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendReg <= '0;
      ackReg  <= '0;
      vecReg  <= '0;
    end else begin
      pendReg <= (pendReg & ~(strobe.accept ? winMask : '0)) | irqReq;
      ackReg  <= strobe.accept ? winMask : '0;
      if (strobe.accept) vecReg <= vecArr[winIdx];
    end
  end

  always_comb begin
    if (strobe.useVec0)      progAddr = vecReg;
    else if (strobe.useVec1) progAddr = vecReg + ADDR_W'(1);
    else                     progAddr = pcAddr;
  end

  assign pcHold = strobe.holdPc;
  assign irqAck = ackReg;

endmodule

// File: rtl/irq_fetch_inserter.sv
module irq_fetch_inserter
  import irq_fetch_pkg::*;
#(
  parameter int NUM_REQ = 4,
  parameter int ADDR_W  = 16
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic [NUM_REQ-1:0]        irqReq,
  input  logic [NUM_REQ*ADDR_W-1:0] vecAddr,
  input  logic [ADDR_W-1:0]         pcAddr,
  input  logic                      instrBoundary,
  input  logic                      excDone,
  output logic [ADDR_W-1:0]         progAddr,
  output logic                      pcHold,
  output logic [NUM_REQ-1:0]        irqAck
);

  ctrlStrobe_t strobe;
  logic        anyPending;

  irq_fetch_ctrl u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .anyPending   (anyPending),
    .instrBoundary(instrBoundary),
    .excDone      (excDone),
    .strobe       (strobe)
  );

  irq_fetch_dpath #(
    .NUM_REQ(NUM_REQ),
    .ADDR_W (ADDR_W)
  ) u_dpath (
    .clk       (clk),
    .rstN      (rstN),
    .irqReq    (irqReq),
    .vecAddr   (vecAddr),
    .pcAddr    (pcAddr),
    .strobe    (strobe),
    .anyPending(anyPending),
    .progAddr  (progAddr),
    .pcHold    (pcHold),
    .irqAck    (irqAck)
  );

endmodule

// File: rtl/irq_fetch_inserter_chk.sv
module irq_fetch_inserter_chk #(
  parameter int NUM_REQ = 4,
  parameter int ADDR_W  = 16
) (
  input logic                 clk,
  input logic                 rstN,
  input logic [ADDR_W-1:0]    pcAddr,
  input logic                 instrBoundary,
  input logic                 excDone,
  input logic [ADDR_W-1:0]    progAddr,
  input logic                 pcHold,
  input logic [NUM_REQ-1:0]   irqAck
);

  AST_ACK_ONEHOT: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(irqAck)); // R7

  AST_ACK_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    (|irqAck) |=> (irqAck == '0)); // R3

  AST_ACK_DECODE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    (|irqAck) |-> (!pcHold && progAddr == pcAddr)); // R3

  AST_ACK_NEEDS_BOUNDARY: assert property (@(posedge clk) disable iff (!rstN)
    (|irqAck) |-> $past(instrBoundary)); // R2

  AST_HOLD_AFTER_ACK: assert property (@(posedge clk) disable iff (!rstN)
    (|irqAck) |=> pcHold); // R4

  AST_SECOND_WORD: assert property (@(posedge clk) disable iff (!rstN)
    $past(|irqAck, 2) |-> (progAddr == $past(progAddr) + ADDR_W'(1))); // R5

  AST_HOLD_UNTIL_DONE: assert property (@(posedge clk) disable iff (!rstN)
    (pcHold && !excDone) |=> pcHold); // R6

  AST_NO_ACK_IN_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    pcHold |-> (irqAck == '0)); // R9

endmodule

bind irq_fetch_inserter irq_fetch_inserter_chk #(
  .NUM_REQ(NUM_REQ),
  .ADDR_W (ADDR_W)
) u_chk (
  .clk          (clk),
  .rstN         (rstN),
  .pcAddr       (pcAddr),
  .instrBoundary(instrBoundary),
  .excDone      (excDone),
  .progAddr     (progAddr),
  .pcHold       (pcHold),
  .irqAck       (irqAck)
);

// File: tb/irq_fetch_inserter_bench.sv
module irq_fetch_inserter_bench;

  localparam int CLK_PERIOD = 10;
  localparam int NUM_REQ    = 4;
  localparam int ADDR_W     = 16;

  logic                      clk = 1'b0;
  logic                      rstN;
  logic [NUM_REQ-1:0]        irqReq;
  logic [NUM_REQ*ADDR_W-1:0] vecAddr;
  logic [ADDR_W-1:0]         pcAddr;
  logic                      instrBoundary;
  logic                      excDone;
  logic [ADDR_W-1:0]         progAddr;
  logic                      pcHold;
  logic [NUM_REQ-1:0]        irqAck;

  int checks   = 0;
  int failures = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_fetch_inserter #(.NUM_REQ(NUM_REQ), .ADDR_W(ADDR_W)) u_irq_fetch_inserter (
    .clk(clk), .rstN(rstN), .irqReq(irqReq), .vecAddr(vecAddr), .pcAddr(pcAddr),
    .instrBoundary(instrBoundary), .excDone(excDone), .progAddr(progAddr),
    .pcHold(pcHold), .irqAck(irqAck)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic setVec(input int idx, input logic [ADDR_W-1:0] a);
    vecAddr[idx*ADDR_W +: ADDR_W] = a;
  endtask

  // starts in the acknowledge cycle; walks the insertion and releases it
  task automatic expectInsertion(input string req, input int idx,
                                 input logic [ADDR_W-1:0] vec);
    chk(req, "ack", 32'(irqAck), 32'(1 << idx));
    chk("R3", "decode addr", 32'(progAddr), 32'(pcAddr));
    chk("R3", "decode hold", 32'(pcHold), 0);
    step();
    chk("R4", "vec0 addr", 32'(progAddr), 32'(vec));
    chk("R4", "vec0 hold", 32'(pcHold), 1);
    step();
    chk("R5", "vec1 addr", 32'(progAddr), 32'(ADDR_W'(vec + 1)));
    chk("R5", "vec1 hold", 32'(pcHold), 1);
    step();
    pcAddr = pcAddr + 16'h0010;
    #1;
    chk("R6", "hold addr", 32'(progAddr), 32'(pcAddr));
    chk("R6", "hold", 32'(pcHold), 1);
    excDone = 1'b1;
    step();
    excDone = 1'b0;
    chk("R6", "released", 32'(pcHold), 0);
  endtask

  task automatic testReset();
    chk("R1", "ack", 32'(irqAck), 0);
    chk("R1", "hold", 32'(pcHold), 0);
    chk("R1", "addr", 32'(progAddr), 32'(pcAddr));
  endtask

  task automatic testBasic();
    irqReq = 4'b0001;
    step();
    irqReq = '0;
    step();
    expectInsertion("R3", 0, 16'h1000);
  endtask

  task automatic testBoundary();
    instrBoundary = 1'b0;
    irqReq = 4'b0010;
    step();
    irqReq = '0;
    for (int i = 0; i < 4; i++) begin
      step();
      chk("R2", "no ack off boundary", 32'(irqAck), 0);
      chk("R2", "addr follows pc", 32'(progAddr), 32'(pcAddr));
    end
    instrBoundary = 1'b1;
    step();
    expectInsertion("R2", 1, 16'h2000);
  endtask

  task automatic testPriority();
    irqReq = 4'b0110;
    step();
    irqReq = '0;
    step();
    expectInsertion("R7", 1, 16'h2000);
    step();
    expectInsertion("R8", 2, 16'h3000);
    step();
    chk("R8", "nothing left", 32'(irqAck), 0);
  endtask

  task automatic testWrap();
    irqReq = 4'b1000;
    step();
    irqReq = '0;
    step();
    expectInsertion("R5", 3, 16'hFFFF);
  endtask

  task automatic testBusy();
    irqReq = 4'b0001;
    step();
    irqReq = '0;
    step();
    chk("R9", "first ack", 32'(irqAck), 1);
    step();
    irqReq = 4'b0100;
    step();
    irqReq = '0;
    for (int i = 0; i < 4; i++) begin
      step();
      chk("R9", "no ack during hold", 32'(irqAck), 0);
      chk("R9", "still held", 32'(pcHold), 1);
    end
    excDone = 1'b1;
    step();
    excDone = 1'b0;
    chk("R9", "idle cycle ack", 32'(irqAck), 0);
    step();
    expectInsertion("R9", 2, 16'h3000);
  endtask

  task automatic testVecLatch();
    irqReq = 4'b0010;
    step();
    irqReq = '0;
    step();
    setVec(1, 16'hABCD);
    expectInsertion("R10", 1, 16'h2000);
    setVec(1, 16'h2000);
  endtask

  task automatic testEarlyDone();
    irqReq = 4'b0001;
    step();
    irqReq = '0;
    step();
    chk("R11", "ack", 32'(irqAck), 1);
    excDone = 1'b1;
    step();
    step();
    step();
    excDone = 1'b0;
    chk("R11", "hold after early done", 32'(pcHold), 1);
    step();
    chk("R11", "hold persists", 32'(pcHold), 1);
    excDone = 1'b1;
    step();
    excDone = 1'b0;
    chk("R11", "released", 32'(pcHold), 0);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    checks++;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rstN = 1'b0;
    irqReq = '0;
    vecAddr = '0;
    pcAddr = 16'h0400;
    instrBoundary = 1'b1;
    excDone = 1'b0;
    setVec(0, 16'h1000);
    setVec(1, 16'h2000);
    setVec(2, 16'h3000);
    setVec(3, 16'hFFFF);
    #1;
    testReset();
    step();
    step();
    rstN = 1'b1;
    step();
    testReset();
    testBasic();
    step();
    testBoundary();
    step();
    testPriority();
    step();
    testWrap();
    step();
    testBusy();
    step();
    testVecLatch();
    step();
    testEarlyDone();
    step();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule